// File: doc/BRIEF.md
# Two-Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. Each transaction is one register access. A requester supplies four things: a port-select flag (access port or debug port), a read flag, a two-bit register address and 32 bits of write data. The engine then generates the serial clock itself. It shifts out an eight-bit request header and releases the data line for one turnaround clock. It then samples a three-bit acknowledge from the target.

- An OK acknowledge leads into the 33-bit data phase. Writes insert a turnaround first. Reads are followed by a turnaround.
- Any other acknowledge skips the data phase. The engine inserts one turnaround and closes the transaction.

When a transaction ends, the engine pulses `done` for one cycle. At the same moment it presents the raw acknowledge, a protocol-error flag, the read data and a read-parity-error flag.

The serial clock runs at the system clock divided by `2*HALF_DIV`. The engine drives host bits while the serial clock is low and changes them only at its falling edge. It samples target bits at the rising edge. Between transactions the serial clock stays low and the data line is driven low.

Top module: `swd_host_engine`

## Requirements
- R1: The header goes out least significant bit first, one bit per serial clock. Its bit layout is: bit0 = 1 (start), bit1 = port select (1 = access port), bit2 = read flag, bits4:3 = address, bit5 = parity, bit6 = 0 (stop), bit7 = 1 (park).
- R2: Header bit5 is 1 exactly when an odd number of {port select, read flag, address[1], address[0]} are 1.
- R3: After the header, the engine releases the line (`swdio_oe` = 0) for one turnaround slot and then for three acknowledge slots. The acknowledge is assembled LSB first, so the first sampled bit is ack[0].
- R4: Acknowledge 3'b001 (OK) continues into the data phase. Acknowledge 3'b010 (WAIT) and 3'b100 (FAULT) end the transaction after one released turnaround slot, 13 slots in total. `rsp_ack` reports the sampled code.
- R5: Any acknowledge value other than 001, 010 or 100 sets `rsp_proto_err` and aborts exactly like WAIT. For the three valid codes, `rsp_proto_err` is 0.
- R6: An OK write adds one released turnaround slot. The engine then drives 32 data bits LSB first, followed by one bit that makes the 33 bits even parity. The transaction is 46 slots.
- R7: An OK read releases the line for 32 data bits (LSB first) plus a parity bit, then adds one released turnaround slot. The transaction is 46 slots. `rsp_rdata` returns the data on an OK read and is 0 otherwise.
- R8: `rsp_parity_err` is 1 only on an OK read whose 33 received bits have odd parity.
- R9: Each serial clock slot lasts `2*HALF_DIV` system cycles, low half first. Host-driven line values never change at a rising serial clock edge.
- R10: `done` is a one-cycle pulse, exactly `slots*2*HALF_DIV` cycles after the accepting edge. `req_ready` is high only while idle, and requests raised while busy are ignored.
- R11: After reset and between transactions, `swclk_o` is 0, `swdio_oe` is 1 and `swdio_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transaction (taken when req_ready) |
| req_ready | output | 1 | Engine idle and able to accept |
| req_ap | input | 1 | 1 selects access port, 0 debug port |
| req_read | input | 1 | 1 for read, 0 for write |
| req_addr | input | 2 | Register address bits [3:2] |
| req_wdata | input | 32 | Write data |
| swclk_o | output | 1 | Serial clock to target |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line value from the pad |
| done | output | 1 | One-cycle transaction-complete pulse |
| rsp_ack | output | 3 | Sampled acknowledge code |
| rsp_proto_err | output | 1 | Acknowledge was not a valid code |
| rsp_rdata | output | 32 | Read data |
| rsp_parity_err | output | 1 | Read data parity mismatch |

## Verification
The bench derives each transaction's slot count from the acknowledge and the direction: 13 slots on an abort, 46 on an OK access. It expects `done` exactly `slots*4` system cycles after the accepting edge, counting from that edge. It then reads the response fields in that same cycle and checks the idle line one cycle later. Host-driven bits and the output enable are compared one time unit after each rising serial clock edge. Target bits are driven one time unit after each falling edge, so each is settled two system cycles before the engine samples it.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    localparam int HDR_BITS  = 8;
    localparam int ACK_BITS  = 3;
    localparam int DATA_BITS = 32;

    localparam logic [ACK_BITS-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_BITS-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_BITS-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_TRN_A,
        PH_ACK,
        PH_TRN_W,
        PH_WDATA,
        PH_RDATA,
        PH_TRN_E
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [5:0]             idx;
        logic [HDR_BITS-1:0]    hdr;
        logic                   rd;
        logic [ACK_BITS-1:0]    ack;
        logic                   sdo;
        logic                   soe;
        logic                   done;
        logic [ACK_BITS-1:0]    r_ack;
        logic                   r_proto;
        logic [DATA_BITS-1:0]   r_data;
        logic                   r_perr;
    } eng_state_t;

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_o,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = $clog2(HALF_DIV) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d = cg_q;
        if (!run) begin
            cg_d.cnt  = '0;
            cg_d.sclk = 1'b0;
        end else if (cg_q.cnt == LAST) begin
            cg_d.cnt  = '0;
            cg_d.sclk = ~cg_q.sclk;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign sclk_o   = cg_q.sclk;
    assign rise_evt = run && (cg_q.cnt == LAST) && !cg_q.sclk;
    assign fall_evt = run && (cg_q.cnt == LAST) &&  cg_q.sclk;

    // R11: a stopped generator leaves the serial clock low
    p_clk_low_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_o);

endmodule

// File: rtl/swd_req_header.sv
module swd_req_header
    import swd_host_pkg::*;
(
    input  logic                ap,
    input  logic                rd,
    input  logic [1:0]          addr,
    output logic [HDR_BITS-1:0] hdr
);
    logic par;

    assign par = ap ^ rd ^ addr[1] ^ addr[0];

    always_comb begin
        hdr      = '0;
        hdr[0]   = 1'b1;
        hdr[1]   = ap;
        hdr[2]   = rd;
        hdr[4:3] = addr;
        hdr[5]   = par;
        hdr[6]   = 1'b0;
        hdr[7]   = 1'b1;
    end

endmodule

// File: rtl/swd_ack_decode.sv
module swd_ack_decode
    import swd_host_pkg::*;
(
    input  logic [ACK_BITS-1:0] ack,
    output logic                ok,
    output logic                proto_err
);
    always_comb begin
        ok        = (ack == ACK_OK);
        proto_err = !((ack == ACK_OK) || (ack == ACK_WAIT) || (ack == ACK_FAULT));
    end

endmodule

// File: rtl/swd_data_shifter.sv
module swd_data_shifter
    import swd_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 shift_out,
    input  logic                 capture,
    input  logic                 din,
    output logic                 lsb_o,
    output logic                 next_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 perr_o
);
    logic [DATA_BITS:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)           sh_d = {^wdata, wdata};
        else if (capture)   sh_d = {din, sh_q[DATA_BITS:1]};
        else if (shift_out) sh_d = {1'b0, sh_q[DATA_BITS:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lsb_o  = sh_q[0];
    assign next_o = sh_q[1];
    assign data_o = sh_q[DATA_BITS-1:0];
    assign perr_o = ^sh_q;

    // R6/R7: the sequencer asks for at most one shifter operation per cycle
    p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, capture, shift_out}));

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_ap,
    input  logic                 req_read,
    input  logic [1:0]           req_addr,
    input  logic [DATA_BITS-1:0] req_wdata,
    output logic                 swclk_o,
    output logic                 swdio_o,
    output logic                 swdio_oe,
    input  logic                 swdio_i,
    output logic                 done,
    output logic [ACK_BITS-1:0]  rsp_ack,
    output logic                 rsp_proto_err,
    output logic [DATA_BITS-1:0] rsp_rdata,
    output logic                 rsp_parity_err
);
    localparam logic [5:0] HDR_LAST  = 6'(HDR_BITS - 1);
    localparam logic [5:0] ACK_LAST  = 6'(ACK_BITS - 1);
    localparam logic [5:0] DATA_LAST = 6'(DATA_BITS);

    eng_state_t st_d, st_q;

    logic                 busy;
    logic                 rise_evt, fall_evt;
    logic [HDR_BITS-1:0]  hdr_w;
    logic                 ack_ok, ack_proto;
    logic                 sh_load, sh_shift, sh_cap;
    logic                 sh_lsb, sh_next, sh_perr;
    logic [DATA_BITS-1:0] sh_data;

    assign busy = (st_q.phase != PH_IDLE);

    swd_clk_gen #(.HALF_DIV(HALF_DIV)) clk_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sclk_o   (swclk_o),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    swd_req_header hdr_i (
        .ap   (req_ap),
        .rd   (req_read),
        .addr (req_addr),
        .hdr  (hdr_w)
    );

    swd_ack_decode ack_i (
        .ack       (st_q.ack),
        .ok        (ack_ok),
        .proto_err (ack_proto)
    );

    swd_data_shifter shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .wdata     (req_wdata),
        .shift_out (sh_shift),
        .capture   (sh_cap),
        .din       (swdio_i),
        .lsb_o     (sh_lsb),
        .next_o    (sh_next),
        .data_o    (sh_data),
        .perr_o    (sh_perr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        sh_cap    = 1'b0;

        if (st_q.phase == PH_IDLE) begin
            st_d.sdo = 1'b0;
            st_d.soe = 1'b1;
            if (req_valid) begin
                st_d.phase = PH_HDR;
                st_d.idx   = '0;
                st_d.hdr   = hdr_w;
                st_d.rd    = req_read;
                st_d.ack   = '0;
                st_d.sdo   = hdr_w[0];
                st_d.soe   = 1'b1;
                sh_load    = 1'b1;
            end
        end else if (rise_evt) begin
            if (st_q.phase == PH_ACK)   st_d.ack[st_q.idx[1:0]] = swdio_i;
            if (st_q.phase == PH_RDATA) sh_cap = 1'b1;
        end else if (fall_evt) begin
            case (st_q.phase)
                PH_HDR: begin
                    if (st_q.idx == HDR_LAST) begin
                        st_d.phase = PH_TRN_A;
                        st_d.idx   = '0;
                        st_d.soe   = 1'b0;
                        st_d.sdo   = 1'b0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.sdo = st_q.hdr[3'(st_q.idx + 1'b1)];
                    end
                end
                PH_TRN_A: begin
                    st_d.phase = PH_ACK;
                    st_d.idx   = '0;
                end
                PH_ACK: begin
                    if (st_q.idx == ACK_LAST) begin
                        st_d.idx = '0;
                        if (ack_ok && st_q.rd)  st_d.phase = PH_RDATA;
                        else if (ack_ok)        st_d.phase = PH_TRN_W;
                        else                    st_d.phase = PH_TRN_E;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_TRN_W: begin
                    st_d.phase = PH_WDATA;
                    st_d.idx   = '0;
                    st_d.soe   = 1'b1;
                    st_d.sdo   = sh_lsb;
                end
                PH_RDATA: begin
                    if (st_q.idx == DATA_LAST) begin
                        st_d.phase = PH_TRN_E;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_WDATA, PH_TRN_E: begin
                    if (st_q.phase == PH_WDATA && st_q.idx != DATA_LAST) begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.sdo = sh_next;
                        sh_shift = 1'b1;
                    end else begin
                        st_d.phase   = PH_IDLE;
                        st_d.idx     = '0;
                        st_d.sdo     = 1'b0;
                        st_d.soe     = 1'b1;
                        st_d.done    = 1'b1;
                        st_d.r_ack   = st_q.ack;
                        st_d.r_proto = ack_proto;
                        st_d.r_data  = (st_q.rd && ack_ok) ? sh_data : '0;
                        st_d.r_perr  = st_q.rd && ack_ok && sh_perr;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.soe   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready      = !busy;
    assign swdio_o        = st_q.sdo;
    assign swdio_oe       = st_q.soe;
    assign done           = st_q.done;
    assign rsp_ack        = st_q.r_ack;
    assign rsp_proto_err  = st_q.r_proto;
    assign rsp_rdata      = st_q.r_data;
    assign rsp_parity_err = st_q.r_perr;

    // R9: host line values never move on a rising serial clock edge
    p_stable_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swclk_o) |-> ($stable(swdio_o) && $stable(swdio_oe)));

    // R11: idle engine keeps clock low and drives line low
    p_idle_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!swclk_o && swdio_oe && !swdio_o));

    // R1: the first driven bit of a transaction is the start bit
    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> (swdio_o && swdio_oe));

    // R3: line released through turnaround and acknowledge
    p_release_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TRN_A || st_q.phase == PH_ACK) |-> !swdio_oe);

    // R10: done is a single-cycle pulse and coincides with idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R8: no parity error reported for a write
    p_perr_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(st_q.rd)) |-> !rsp_parity_err);

endmodule

// File: tb/swd_host_engine_tb_top.sv
module swd_host_engine_tb_top;
    localparam int HALF = 2;
    localparam int SLOT_CYC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ap = 1'b0;
    logic        req_read = 1'b0;
    logic [1:0]  req_addr = 2'b00;
    logic [31:0] req_wdata = '0;
    logic        swclk_o, swdio_o, swdio_oe;
    logic        swdio_i = 1'b0;
    logic        done;
    logic [2:0]  rsp_ack;
    logic        rsp_proto_err;
    logic [31:0] rsp_rdata;
    logic        rsp_parity_err;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;

    logic exp_oe [0:45];
    logic exp_o  [0:45];
    logic tgt    [0:45];
    int   nslots;
    int   err_hdr, err_rel, err_dat;

    always #4 clk = ~clk;

    swd_host_engine #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_ap(req_ap), .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
        .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
        .done(done), .rsp_ack(rsp_ack), .rsp_proto_err(rsp_proto_err),
        .rsp_rdata(rsp_rdata), .rsp_parity_err(rsp_parity_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, misses + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic build(input bit ap, input bit rd, input bit [1:0] addr,
                         input bit [31:0] wd, input bit [2:0] ack,
                         input bit [31:0] rdv, input bit flip);
        bit [7:0] h;
        h    = 8'h81;
        h[1] = ap; h[2] = rd; h[4:3] = addr;
        h[5] = (ap + rd + addr[1] + addr[0]) % 2;
        for (int k = 0; k < 46; k++) begin exp_oe[k] = 1'b0; exp_o[k] = 1'b0; tgt[k] = 1'b0; end
        for (int k = 0; k < 8; k++) begin exp_oe[k] = 1'b1; exp_o[k] = h[k]; end
        for (int k = 0; k < 3; k++) tgt[9 + k] = ack[k];
        if (ack != 3'b001) begin
            nslots = 13;
        end else if (!rd) begin
            nslots = 46;
            for (int k = 0; k < 32; k++) begin exp_oe[13 + k] = 1'b1; exp_o[13 + k] = wd[k]; end
            exp_oe[45] = 1'b1; exp_o[45] = ^wd;
        end else begin
            nslots = 46;
            for (int k = 0; k < 32; k++) tgt[12 + k] = rdv[k];
            tgt[44] = (^rdv) ^ flip;
        end
    endtask

    task automatic monitor();
        for (int k = 0; k < nslots; k++) begin
            @(posedge swclk_o); #1;
            if (swdio_oe !== exp_oe[k] || (exp_oe[k] && swdio_o !== exp_o[k])) begin
                if (k < 8)                 err_hdr++;
                else if (k < 12 || !exp_oe[k]) err_rel++;
                else                       err_dat++;
            end
            @(negedge swclk_o); #1;
            if (k + 1 < nslots) swdio_i = tgt[k + 1];
        end
    endtask

    task automatic run_txn(input bit ap, input bit rd, input bit [1:0] addr,
                           input bit [31:0] wd, input bit [2:0] ack,
                           input bit [31:0] rdv, input bit flip, input bit busy_req);
        int  cyc;
        bit  seen;
        bit  ok;
        ok = (ack == 3'b001);
        build(ap, rd, addr, wd, ack, rdv, flip);
        err_hdr = 0; err_rel = 0; err_dat = 0;
        @(negedge clk);
        req_ap = ap; req_read = rd; req_addr = addr; req_wdata = wd;
        swdio_i = tgt[0];
        req_valid = 1'b1;
        cyc = 0; seen = 1'b0;
        fork
            monitor();
            begin
                @(posedge clk); #1;
                req_valid = 1'b0;
                while (!seen && cyc < 1000) begin
                    @(posedge clk); #1;
                    cyc++;
                    if (busy_req && cyc == 10) begin
                        req_valid = 1'b1; req_ap = ~ap; req_read = ~rd; req_addr = ~addr;
                        req_wdata = ~wd;
                    end
                    if (busy_req && cyc == 13) req_valid = 1'b0;
                    if (done) seen = 1'b1;
                end
            end
        join
        chk(err_hdr == 0, "R1/R2 header bits", err_hdr, 0);
        chk(err_rel == 0, "R3/R7 released slots", err_rel, 0);
        chk(err_dat == 0, "R6 write data bits", err_dat, 0);
        chk(cyc == nslots * SLOT_CYC, "R10 done latency", cyc, nslots * SLOT_CYC);
        chk(rsp_ack == ack, "R4 ack code", rsp_ack, ack);
        chk(rsp_proto_err == !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100),
            "R5 protocol error", rsp_proto_err,
            !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100));
        chk(rsp_rdata == ((rd && ok) ? rdv : 32'h0), "R7 read data", rsp_rdata,
            (rd && ok) ? rdv : 32'h0);
        chk(rsp_parity_err == (rd && ok && flip), "R8 parity error", rsp_parity_err,
            rd && ok && flip);
        @(posedge clk); #1;
        chk(!done && req_ready && !swclk_o && swdio_oe && !swdio_o,
            "R10/R11 idle after done", {done, req_ready, swclk_o, swdio_oe, swdio_o}, 5'b01010);
        if (busy_req) begin
            cyc = 0;
            repeat (20) begin @(posedge clk); #1; if (swclk_o || done) cyc++; end
            chk(cyc == 0, "R10 busy request ignored", cyc, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready && !swclk_o && swdio_oe && !swdio_o && !done, "R11 reset state",
            {req_ready, swclk_o, swdio_oe, swdio_o, done}, 5'b10100);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(req_ready && !swclk_o && swdio_oe && !swdio_o, "R11 idle after reset",
            {req_ready, swclk_o, swdio_oe, swdio_o}, 4'b1010);

        // R1 R2 R6 R7 R8 R9: every header combination with an OK acknowledge
        for (int n = 0; n < 16; n++) begin
            bit [31:0] pat;
            pat = (32'h1 << (n * 2)) ^ (32'(n) * 32'h9E37_79B9);
            run_txn(n[0], n[1], n[3:2], pat, 3'b001, ~pat ^ 32'(n), (n % 3) == 0, 1'b0);
        end
        // R4 R5: every acknowledge value, both directions
        for (int a = 0; a < 8; a++) begin
            if (a != 1) begin
                run_txn(1'b1, 1'b0, 2'(a), 32'hA5A5_0F0F, 3'(a), 32'h0, 1'b0, 1'b0);
                run_txn(1'b0, 1'b1, 2'(a), 32'h0, 3'(a), 32'hFFFF_FFFF, 1'b1, 1'b0);
            end
        end
        // R10: requests raised while busy are ignored
        run_txn(1'b1, 1'b0, 2'b10, 32'h8000_0001, 3'b001, 32'h0, 1'b0, 1'b1);
        run_txn(1'b0, 1'b1, 2'b01, 32'h0, 3'b001, 32'h0000_0000, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule